// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Staged Commit

The block produces one pulse-width-modulated output from a phase accumulator. On every step a programmable increment is added to an `ACC_W`-bit accumulator. Each wrap of the accumulator closes one output period, so the period in steps is 2^ACC_W divided by the increment. The top eight accumulator bits are compared against an on-time threshold, which gives 256 duty steps.

Software sees a single 32-bit control word. The increment and threshold fields written there only go into a staging copy. The running generator keeps its active pair until a write sets the commit bit, and the copy then happens at the next accumulator wrap. Because of this, a period never ends part-way through with mixed settings. A separate input switches the step rate from every clock to once every `SLOW_RATIO` clocks. This models a slow reference clock.

Top module: `phacc_pwm`

## Requirements
- R1: After a synchronous reset, `pwm_out` is low and `rd_data` reads zero.
- R2: When enabled with a nonzero active increment in fast mode, the output period is exactly 2^ACC_W / increment clocks (increment a power of two).
- R3: `pwm_out` is high in the clock after a cycle where accumulator bits [ACC_W-1:ACC_W-8] are below the active on-time. An on-time of 0 keeps the output low.
- R4: An active increment of zero adds nothing to the accumulator, and the output stays continuously low.
- R5: A write with bit 30 clear updates the staged fields shown in `rd_data`, but the active increment and on-time do not change.
- R6: Bit 30 set by a write reads back as 1 while a commit is pending. It clears in the cycle the staged pair becomes active. The commit happens at the next accumulator wrap, or one cycle later if the generator is disabled or the active increment is zero.
- R7: Bit 31 enables the generator from the cycle after the write. While it is clear, the accumulator is held at zero and the output is low. Writing 0xC0000000 together with fields both enables and commits.
- R8: With `slow_sel` high, the accumulator advances only once every `SLOW_RATIO` clocks, so the period grows by that factor.
- R9: The field layout is on-time in bits [7:0] and increment in bits [ACC_W+7:8]. Bits [29:ACC_W+8] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| slow_sel | input | 1 | Selects the slow step rate |
| rd_data | output | 32 | Control word read-back (staged fields) |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest state to reach is a commit request that is still pending when a second write arrives. The second write either replaces the staged pair or drops the commit bit before the wrap lands. A related case is a commit that is held up by a long slow-mode period. Random writes at random intervals of a few clocks create these overlaps, and a cycle-level reference model in the bench checks each one. Directed sequences measure the period and the high time, check the zero-increment case, and stage values without committing them.

// File: rtl/phacc_pwm_pkg.sv
package phacc_pwm_pkg;
  localparam int ENABLE_BIT = 31;
  localparam int COMMIT_BIT = 30;
  localparam int DUTY_W     = 8;
  localparam int DUTY_LSB   = 0;
  localparam int STEP_LSB   = DUTY_W;

  typedef struct packed {
    logic       en;
    logic       pend;
  } ctl_t;
endpackage

// File: rtl/phacc_pwm_regs.sv
module phacc_pwm_regs #(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              wrap,
  output logic              en_q,
  output logic              pend_q,
  output logic [ACC_W-1:0]  stage_step,
  output logic [7:0]        stage_duty,
  output logic [ACC_W-1:0]  act_step,
  output logic [7:0]        act_duty
);
  import phacc_pwm_pkg::*;

  logic commit;
  assign commit = pend_q && (!en_q || (act_step == '0) || wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      stage_step <= '0;
      stage_duty <= '0;
      act_step   <= '0;
      act_duty   <= '0;
    end else begin
      if (commit) begin
        act_step <= stage_step;
        act_duty <= stage_duty;
      end
      if (wr_en) begin
        en_q       <= wr_data[ENABLE_BIT];
        stage_step <= wr_data[STEP_LSB +: ACC_W];
        stage_duty <= wr_data[DUTY_LSB +: DUTY_W];
      end
      pend_q <= (pend_q && !commit) || (wr_en && wr_data[COMMIT_BIT]);
    end
  end
endmodule

// File: rtl/phacc_pwm_accum.sv
module phacc_pwm_accum #(
  parameter int ACC_W      = 16,
  parameter int SLOW_RATIO = 600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             slow_sel,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc,
  output logic             wrap
);
  localparam int PRE_W = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

  logic [PRE_W-1:0] pre;
  logic             tick;
  logic [ACC_W:0]   sum;

  assign tick = !slow_sel || (pre == PRE_W'(SLOW_RATIO - 1));
  assign sum  = {1'b0, acc} + {1'b0, step};
  assign wrap = en && tick && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || !slow_sel || tick) pre <= '0;
    else                          pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) acc <= '0;
    else if (tick)  acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/phacc_pwm_cmp.sv
module phacc_pwm_cmp #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  input  logic [ACC_W-1:0] acc,
  input  logic [7:0]       duty,
  output logic             pwm_out
);
  logic [7:0] phase;
  assign phase = acc[ACC_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= en && (step != '0) && (phase < duty);
  end
endmodule

// File: rtl/phacc_pwm.sv
module phacc_pwm #(
  parameter int ACC_W      = 16,
  parameter int SLOW_RATIO = 600
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        slow_sel,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  import phacc_pwm_pkg::*;
  localparam int PAD_W = COMMIT_BIT - STEP_LSB - ACC_W;

  logic             en_q, pend_q, wrap;
  logic [ACC_W-1:0] stage_step, act_step, acc;
  logic [7:0]       stage_duty, act_duty;
  ctl_t             ctl;

  phacc_pwm_regs #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wrap(wrap),
    .en_q(en_q), .pend_q(pend_q), .stage_step(stage_step),
    .stage_duty(stage_duty), .act_step(act_step), .act_duty(act_duty)
  );

  phacc_pwm_accum #(.ACC_W(ACC_W), .SLOW_RATIO(SLOW_RATIO)) u_acc (
    .clk(clk), .rst(rst), .en(en_q), .slow_sel(slow_sel),
    .step(act_step), .acc(acc), .wrap(wrap)
  );

  phacc_pwm_cmp #(.ACC_W(ACC_W)) u_cmp (
    .clk(clk), .rst(rst), .en(en_q), .step(act_step), .acc(acc),
    .duty(act_duty), .pwm_out(pwm_out)
  );

  assign ctl = '{en: en_q, pend: pend_q};

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {ctl.en, ctl.pend, {PAD_W{1'b0}}, stage_step, stage_duty};
    end else begin : g_nopad
      assign rd_data = {ctl.en, ctl.pend, stage_step, stage_duty};
    end
  endgenerate
endmodule

// File: rtl/phacc_pwm_checker.sv
module phacc_pwm_checker #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             pwm_out,
  input logic [ACC_W-1:0] act_step,
  input logic [7:0]       act_duty,
  input logic [ACC_W-1:0] acc
);
  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_data[31] |=> !pwm_out);

  assert_disabled_acc_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_data[31] |=> (acc == '0));

  assert_zero_step_low_R4: assert property (@(posedge clk) disable iff (rst)
    (act_step == '0) |=> !pwm_out);

  assert_active_held_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_data[30] |=> ($stable(act_step) && $stable(act_duty)));

  assert_commit_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data[30] && !rd_data[31] && !(wr_en && wr_data[30])) |=> !rd_data[30]);

  assert_zero_duty_low_R3: assert property (@(posedge clk) disable iff (rst)
    (act_duty == 8'd0) |=> !pwm_out);
endmodule

bind phacc_pwm phacc_pwm_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .pwm_out(pwm_out), .act_step(act_step), .act_duty(act_duty), .acc(acc)
);

// File: tb/phacc_pwm_test.sv
module phacc_pwm_test;
  localparam int ACC_W = 16;
  localparam int RATIO = 600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        slow_sel = 1'b0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int total = 0, bad = 0;
  int cyc = 0;
  bit done = 0;

  phacc_pwm #(.ACC_W(ACC_W), .SLOW_RATIO(RATIO)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .slow_sel(slow_sel), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // reference model, built from the requirements
  bit              m_en, m_pend, m_out;
  bit [ACC_W-1:0]  m_ss, m_as, m_acc;
  bit [7:0]        m_sd, m_ad;
  int              m_pre;
  bit              model_on = 0;

  always @(posedge clk) begin
    bit tick, wrapped, cm;
    bit [ACC_W:0] s;
    cyc++;
    if (rst) begin
      m_en = 0; m_pend = 0; m_out = 0; m_ss = 0; m_as = 0;
      m_acc = 0; m_sd = 0; m_ad = 0; m_pre = 0;
    end else begin
      tick = !slow_sel || (m_pre == RATIO - 1);
      s = {1'b0, m_acc} + {1'b0, m_as};
      wrapped = m_en && tick && s[ACC_W];
      cm = m_pend && (!m_en || m_as == 0 || wrapped);
      m_out = m_en && (m_as != 0) && (m_acc[ACC_W-1 -: 8] < m_ad);
      m_pre = (!slow_sel || tick) ? 0 : m_pre + 1;
      if (!m_en) m_acc = 0; else if (tick) m_acc = s[ACC_W-1:0];
      if (cm) begin m_as = m_ss; m_ad = m_sd; end
      m_pend = (m_pend && !cm) || (wr_en && wr_data[30]);
      if (wr_en) begin
        m_en = wr_data[31]; m_ss = wr_data[8 +: ACC_W]; m_sd = wr_data[7:0];
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      total++;
      if (pwm_out !== m_out) begin
        bad++;
        $display("FAIL R2/R3 model cycle %0d: pwm actual=%0b expected=%0b", cyc, pwm_out, m_out);
      end
      total++;
      if (rd_data !== {m_en, m_pend, 6'b0, m_ss, m_sd}) begin
        bad++;
        $display("FAIL R6/R9 model readback: actual=%h expected=%h",
                 rd_data, {m_en, m_pend, 6'b0, m_ss, m_sd});
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit upd, input int step, input int duty);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {en, upd, 6'b0, step[ACC_W-1:0], duty[7:0]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += pwm_out;
    end
  endtask

  task automatic period(output int p);
    bit prev;
    int a, b;
    prev = pwm_out; a = -1; b = -1; p = 0;
    for (int i = 0; i < 20000 && b < 0; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin
        if (a < 0) a = i; else b = i;
      end
      prev = pwm_out;
    end
    p = b - a;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int h, p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pwm", pwm_out, 0);
    check("R1 reset readback", rd_data, 0);
    model_on = 1;

    // R7 enable+commit together (0xC0000000 with fields), R2 period, R3 duty
    wr(1, 1, 16'h1000, 128);
    repeat (4) @(negedge clk);
    period(p);
    check("R2 period step 0x1000", p, 16);
    high_count(64, h);
    check("R3 duty 128 high count", h, 32);
    check("R6 commit cleared", rd_data[30], 0);

    // R5 stage without commit
    wr(1, 0, 16'h2000, 128);
    check("R9 staged step field", rd_data[23:8], 16'h2000);
    check("R5 pending stays clear", rd_data[30], 0);
    period(p);
    check("R5 period unchanged", p, 16);

    // R6 commit later at wrap
    wr(1, 1, 16'h2000, 64);
    repeat (20) @(negedge clk);
    check("R6 pending cleared after wrap", rd_data[30], 0);
    period(p);
    check("R2 period step 0x2000", p, 8);
    high_count(64, h);
    check("R3 duty 64 high count", h, 16);

    // R3 full and zero duty
    wr(1, 1, 16'h1000, 255);
    repeat (20) @(negedge clk);
    high_count(64, h);
    check("R3 duty 255 high count", h, 64);
    wr(1, 1, 16'h1000, 0);
    repeat (20) @(negedge clk);
    high_count(64, h);
    check("R3 duty 0 high count", h, 0);

    // R4 zero step
    wr(1, 1, 0, 200);
    repeat (20) @(negedge clk);
    high_count(300, h);
    check("R4 zero step high count", h, 0);
    wr(1, 1, 16'h1000, 128);
    repeat (3) @(negedge clk);
    check("R6 commit out of zero step", rd_data[30], 0);

    // R7 disable
    wr(0, 0, 16'h1000, 128);
    high_count(100, h);
    check("R7 disabled high count", h, 0);
    wr(1, 0, 16'h1000, 128);
    period(p);
    check("R7 re-enable period", p, 16);

    // R9 reserved bits
    @(negedge clk); wr_en = 1; wr_data = 32'h3FFF_FFFF; @(negedge clk); wr_en = 0;
    check("R9 reserved bits zero", rd_data[29:24], 0);

    // R8 slow mode
    wr(1, 1, 16'h4000, 128);
    repeat (20) @(negedge clk);
    slow_sel = 1'b1;
    period(p);
    period(p);
    check("R8 slow period", p, 4 * RATIO);
    slow_sel = 1'b0;

    // random mix, checked by the model every cycle
    for (int k = 0; k < 600; k++) begin
      bit e, u;
      int st, du, gap;
      e  = ($urandom % 8) != 0;
      u  = $urandom % 2;
      st = ($urandom % 4 == 0) ? 0 : $urandom;
      du = $urandom;
      gap = $urandom % 40;
      if (k % 100 == 50) slow_sel = 1'b1;
      if (k % 100 == 53) slow_sel = 1'b0;
      wr(e, u, st, du);
      repeat (gap) @(negedge clk);
    end

    done = 1;
    finish_run();
  end
endmodule